// File: doc/BRIEF.md
# Ethernet receive address filter

This block sits beside a receive MAC and decides, once per frame, whether the frame is kept or thrown away. Bytes arrive one per qualified cycle with start and end markers. The block captures the six destination-address bytes. It runs a CRC-32 over those bytes as they arrive and counts the length of the frame. When the last byte has arrived, it issues a single registered accept/drop verdict.

Three independent filters can be switched on through a small write-only register port. The first compares a unicast destination against two stored station addresses. The second looks up a multicast destination in a 128-bin hash table. The third drops runt frames shorter than a programmable minimum length. When all three filters are off, every frame is accepted. Broadcast frames are never dropped by the address filters.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset `decValid` is 0, and it stays 0 until a frame has been completed.
- R2: For the byte taken with `inValid`=1 and `inEnd`=1 at clock edge k, `decValid` is 1 for exactly the one cycle that follows edge k+1, and `decAccept` carries the verdict in that same cycle. A byte with `inValid`=1 and `inStart`=1 begins a frame. Later bytes with `inValid`=1 belong to that frame.
- R3: When the three enable bits of the control word are all 0, every frame is accepted, including frames shorter than six bytes.
- R4: Register writes take effect at the clock edge where `cfgWe`=1. Register addresses:
  - 0: control word. Bit 0 enables unicast filtering, bit 1 enables multicast filtering, bit 2 enables runt filtering, and bits 31:16 hold the minimum length in bytes.
  - 1: bytes 2..5 of station address A, with byte 2 in bits 7:0 and byte 5 in bits 31:24.
  - 2: the same layout for station address B.
  - 3: byte 0 of A in bits 7:0, byte 1 of A in bits 15:8, byte 0 of B in bits 23:16 and byte 1 of B in bits 31:24.
  - 4..7: hash words 0..3.
- R5: When unicast filtering is enabled, a unicast frame whose destination equals all six bytes of either station address is accepted. A frame that matches neither address in full is dropped, including a frame that mixes the upper bytes of one address with the lower bytes of the other.
- R6: When unicast filtering is disabled, unicast frames pass the address check whatever their destination.
- R7: A destination is multicast when bit 0 of its first byte is 1.
  - CRC definition: the register starts at all ones. Each byte is fed least significant bit first. For each bit, the register shifts left and is XORed with 0x04C11DB7 when the old bit 31 differs from the data bit. There is no final inversion.
  - The hash index is CRC bits 29:23 of the six destination bytes. Bits 6:5 of the index pick the hash word and bits 4:0 pick the bit within it.
  - With multicast filtering enabled, a multicast frame is accepted exactly when that bit is 1.
- R8: With multicast filtering disabled, every multicast frame passes the address check, whatever the hash words hold.
- R9: A destination of all ones is accepted whatever the unicast and hash settings, provided the frame passes the length checks.
- R10: With runt filtering enabled, a frame whose byte count is below the minimum length is dropped. A frame whose count equals or exceeds the minimum is not dropped for its length.
- R11: When any enable bit is set, a frame with fewer than six bytes is dropped.
- R12: A start byte that arrives inside an unfinished frame abandons that frame without a verdict, and a new frame begins from that byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 3 | Register address |
| cfgWdata | input | 32 | Register write data |
| inValid | input | 1 | Byte qualifier |
| inStart | input | 1 | First byte of a frame |
| inEnd | input | 1 | Last byte of a frame |
| inData | input | 8 | Frame byte |
| decValid | output | 1 | One-cycle verdict strobe |
| decAccept | output | 1 | Verdict: 1 keeps the frame, 0 drops it |

## Verification
The hardest case to reach from the ports is a multicast verdict that depends on one particular hash bit. The index is a CRC of the address, so no input pattern sets it directly. The bench therefore computes the CRC of each chosen group address itself. It writes only the selected bit, then its complement, then the same bit in a different word, so a wrong word or bit select shows up as a wrong verdict. Frame restarts are driven by opening a partial frame and starting a new one before it ends. One case matches an address in the abandoned frame and the other matches it only in the new one.

// File: rtl/rx_addr_filter_pkg.sv
package rx_addr_filter_pkg;
  parameter int LEN_W = 16;

  // strobes from control to datapath
  typedef struct packed {
    logic start;   // byte opens a new frame
    logic take;    // byte belongs to the current frame
  } strobe_t;

  // frame observations returned by the datapath
  typedef struct packed {
    logic             isBcast;
    logic             isMcast;
    logic             uniHit;
    logic             hashHit;
    logic             addrFull;
    logic [LEN_W-1:0] frameLen;
  } flags_t;
endpackage

// File: rtl/rx_addr_filter_dp.sv
module rx_addr_filter_dp
  import rx_addr_filter_pkg::*;
#(
  parameter int CFG_AW     = 3,
  parameter int WORD_W     = 32,
  parameter int HASH_WORDS = 4,
  parameter int HASH_BASE  = 4,
  parameter int IDX_LSB    = 23
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [WORD_W-1:0] cfgWdata,
  input  logic [7:0]        inData,
  input  strobe_t           strb,
  output flags_t            flags
);
  localparam int ADDR_BYTES = 6;
  localparam int ADDR_W     = ADDR_BYTES * 8;
  localparam int HASH_BITS  = HASH_WORDS * WORD_W;
  localparam int IDX_W      = $clog2(HASH_BITS);
  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
  localparam logic [CFG_AW-1:0] ADR_LO_A = CFG_AW'(1);
  localparam logic [CFG_AW-1:0] ADR_LO_B = CFG_AW'(2);
  localparam logic [CFG_AW-1:0] ADR_HI   = CFG_AW'(3);
  localparam logic [LEN_W-1:0]  LEN_ADDR = LEN_W'(ADDR_BYTES);

  logic [WORD_W-1:0]    uniLoA, uniLoB, uniHi;
  logic [WORD_W-1:0]    hashWord [HASH_WORDS];
  logic [HASH_BITS-1:0] hashFlat;
  logic [ADDR_W-1:0]    destReg;
  logic [31:0]          crcReg;
  logic [LEN_W-1:0]     frameLen;
  logic [ADDR_W-1:0]    addrA, addrB;
  logic [IDX_W-1:0]     hashIdx;

  function automatic logic [31:0] crcStep(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int j = 0; j < 8; j++) begin
      if (r[31] ^ b[j]) r = (r << 1) ^ CRC_POLY;
      else              r = r << 1;
    end
    return r;
  endfunction

  // configuration storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      uniLoA <= '0;
      uniLoB <= '0;
      uniHi  <= '0;
      for (int i = 0; i < HASH_WORDS; i++) hashWord[i] <= '0;
    end else if (cfgWe) begin
      if (cfgAddr == ADR_LO_A) uniLoA <= cfgWdata;
      if (cfgAddr == ADR_LO_B) uniLoB <= cfgWdata;
      if (cfgAddr == ADR_HI)   uniHi  <= cfgWdata;
      for (int i = 0; i < HASH_WORDS; i++)
        if (cfgAddr == CFG_AW'(HASH_BASE + i)) hashWord[i] <= cfgWdata;
    end
  end

  genvar w;
  generate
    for (w = 0; w < HASH_WORDS; w++) begin : g_flat
      assign hashFlat[w*WORD_W +: WORD_W] = hashWord[w];
    end
  endgenerate

  // first destination byte ends up in the top byte of the vector
  assign addrA = {uniHi[7:0],   uniHi[15:8],  uniLoA[7:0], uniLoA[15:8], uniLoA[23:16], uniLoA[31:24]};
  assign addrB = {uniHi[23:16], uniHi[31:24], uniLoB[7:0], uniLoB[15:8], uniLoB[23:16], uniLoB[31:24]};

  // per-frame capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      destReg  <= '0;
      crcReg   <= '1;
      frameLen <= '0;
    end else if (strb.start) begin
      destReg  <= {{(ADDR_W-8){1'b0}}, inData};
      crcReg   <= crcStep(32'hFFFF_FFFF, inData);
      frameLen <= LEN_W'(1);
    end else if (strb.take) begin
      if (frameLen < LEN_ADDR) begin
        destReg <= {destReg[ADDR_W-9:0], inData};
        crcReg  <= crcStep(crcReg, inData);
      end
      if (frameLen != '1) frameLen <= frameLen + LEN_W'(1);
    end
  end

  assign hashIdx        = crcReg[IDX_LSB +: IDX_W];
  assign flags.isBcast  = &destReg;
  assign flags.isMcast  = destReg[ADDR_W-8];
  assign flags.uniHit   = (destReg == addrA) || (destReg == addrB);
  assign flags.hashHit  = hashFlat[hashIdx];
  assign flags.addrFull = frameLen >= LEN_ADDR;
  assign flags.frameLen = frameLen;

  AST_LEN_GROWS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.take && !strb.start) |=> (frameLen >= $past(frameLen))); // R10
  AST_HASH_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWe |=> $stable(hashFlat)); // R4
endmodule

// File: rtl/rx_addr_filter_ctl.sv
module rx_addr_filter_ctl
  import rx_addr_filter_pkg::*;
#(
  parameter int CFG_AW  = 3,
  parameter int WORD_W  = 32,
  parameter int MIN_LSB = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [WORD_W-1:0] cfgWdata,
  input  logic              inValid,
  input  logic              inStart,
  input  logic              inEnd,
  input  flags_t            flags,
  output strobe_t           strb,
  output logic              decValid,
  output logic              decAccept
);
  localparam int UNI_BIT  = 0;
  localparam int MC_BIT   = 1;
  localparam int FRAG_BIT = 2;
  localparam logic [CFG_AW-1:0] ADR_CTRL = '0;

  typedef enum logic {ST_IDLE, ST_BUSY} state_e;
  state_e           state;
  logic             uniEn, mcEn, fragEn;
  logic [LEN_W-1:0] minLen;
  logic             judgePend;
  logic             lenOk, anyEn, verdict;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      uniEn  <= 1'b0;
      mcEn   <= 1'b0;
      fragEn <= 1'b0;
      minLen <= '0;
    end else if (cfgWe && cfgAddr == ADR_CTRL) begin
      uniEn  <= cfgWdata[UNI_BIT];
      mcEn   <= cfgWdata[MC_BIT];
      fragEn <= cfgWdata[FRAG_BIT];
      minLen <= cfgWdata[MIN_LSB +: LEN_W];
    end
  end

  assign strb.start = inValid && inStart;
  assign strb.take  = inValid && (inStart || state == ST_BUSY);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      judgePend <= 1'b0;
    end else begin
      judgePend <= strb.take && inEnd;
      if (strb.take && inEnd) state <= ST_IDLE;
      else if (strb.start)    state <= ST_BUSY;
    end
  end

  assign lenOk = flags.frameLen >= minLen;
  assign anyEn = uniEn || mcEn || fragEn;

  always_comb begin
    verdict = 1'b1;
    if (anyEn) begin
      if (!flags.addrFull)       verdict = 1'b0;
      else if (fragEn && !lenOk) verdict = 1'b0;
      else if (flags.isBcast)    verdict = 1'b1;
      else if (flags.isMcast)    verdict = !mcEn || flags.hashHit;
      else                       verdict = !uniEn || flags.uniHit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decValid  <= 1'b0;
      decAccept <= 1'b0;
    end else begin
      decValid  <= judgePend;
      decAccept <= judgePend && verdict;
    end
  end

  AST_DEC_AFTER_END: assert property (@(posedge clk) disable iff (!rstN)
    decValid |-> $past(inValid && inEnd, 2)); // R2
  AST_OPEN_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && $past(!anyEn)) |-> decAccept); // R3
  AST_RUNT_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && $past(fragEn && !lenOk)) |-> !decAccept); // R10
  AST_SHORT_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && $past(anyEn && !flags.addrFull)) |-> !decAccept); // R11
  AST_BCAST_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && $past(flags.isBcast && flags.addrFull && !(fragEn && !lenOk))) |-> decAccept); // R9
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rx_addr_filter_pkg::*;
#(
  parameter int CFG_AW     = 3,
  parameter int WORD_W     = 32,
  parameter int HASH_WORDS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [WORD_W-1:0] cfgWdata,
  input  logic              inValid,
  input  logic              inStart,
  input  logic              inEnd,
  input  logic [7:0]        inData,
  output logic              decValid,
  output logic              decAccept
);
  strobe_t strb;
  flags_t  flags;

  rx_addr_filter_ctl #(.CFG_AW(CFG_AW), .WORD_W(WORD_W)) u_ctl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .inValid(inValid), .inStart(inStart), .inEnd(inEnd), .flags(flags),
    .strb(strb), .decValid(decValid), .decAccept(decAccept)
  );

  rx_addr_filter_dp #(.CFG_AW(CFG_AW), .WORD_W(WORD_W), .HASH_WORDS(HASH_WORDS)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .inData(inData), .strb(strb), .flags(flags)
  );
endmodule

// File: tb/sim_rx_addr_filter.sv
module sim_rx_addr_filter;
  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWe;
  logic [2:0]  cfgAddr;
  logic [31:0] cfgWdata;
  logic        inValid, inStart, inEnd;
  logic [7:0]  inData;
  logic        decValid, decAccept;

  int nChecks = 0;
  int nFails  = 0;
  logic [7:0] fb [0:127];

  localparam logic [47:0] ADDR_A = 48'h00_11_22_33_44_55;
  localparam logic [47:0] ADDR_B = 48'h02_AA_BB_CC_DD_EE;
  localparam logic [47:0] BCAST  = 48'hFF_FF_FF_FF_FF_FF;

  always #5 clk = ~clk;

  rx_addr_filter u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .inValid(inValid), .inStart(inStart), .inEnd(inEnd), .inData(inData),
    .decValid(decValid), .decAccept(decAccept)
  );

  function automatic logic [31:0] destCrc(input logic [47:0] da);
    logic [31:0] c;
    logic [7:0]  b;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < 6; i++) begin
      b = da[47 - 8*i -: 8];
      for (int j = 0; j < 8; j++) begin
        if (c[31] ^ b[j]) c = (c << 1) ^ 32'h04C11DB7;
        else              c = c << 1;
      end
    end
    return c;
  endfunction

  function automatic logic [31:0] ctrlWord(input logic u, input logic m, input logic f, input logic [15:0] ml);
    return {ml, 13'd0, f, m, u};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic fillFrame(input logic [47:0] da, input int len);
    for (int i = 0; i < 128; i++) fb[i] = 8'(i + 16);
    for (int i = 0; i < 6; i++) fb[i] = da[47 - 8*i -: 8];
    if (len < 0) fb[0] = 8'h00;
  endtask

  task automatic sendFrame(input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      inValid = 1'b1; inData = fb[i];
      inStart = (i == 0); inEnd = (i == len - 1);
    end
    @(negedge clk);
    inValid = 1'b0; inStart = 1'b0; inEnd = 1'b0;
  endtask

  task automatic expectDec(input string req, input string what, input logic exp);
    @(negedge clk);
    chk(req, {what, " strobe"}, 32'(decValid), 32'd1);
    chk(req, what, 32'(decAccept), 32'(exp));
    @(negedge clk);
    chk("R2", {what, " strobe width"}, 32'(decValid), 32'd0);
  endtask

  task automatic runFrame(input logic [47:0] da, input int len, input logic exp, input string req, input string what);
    fillFrame(da, len);
    sendFrame(len);
    expectDec(req, what, exp);
  endtask

  task automatic testReset;
    rstN = 1'b0; cfgWe = 1'b0; cfgAddr = '0; cfgWdata = '0;
    inValid = 1'b0; inStart = 1'b0; inEnd = 1'b0; inData = '0;
    repeat (4) @(negedge clk);
    chk("R1", "decValid in reset", 32'(decValid), 32'd0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "decValid idle", 32'(decValid), 32'd0);
  endtask

  task automatic testOpen;
    cfgWrite(3'd0, 32'd0);
    runFrame(48'h0A_0B_0C_0D_0E_0F, 1, 1'b1, "R3", "one-byte frame open");
    runFrame(48'h0A_0B_0C_0D_0E_0F, 10, 1'b1, "R3", "unicast open");
    runFrame(48'h01_00_5E_00_00_07, 64, 1'b1, "R2", "multicast open");
  endtask

  task automatic testUnicast;
    cfgWrite(3'd1, {ADDR_A[7:0], ADDR_A[15:8], ADDR_A[23:16], ADDR_A[31:24]});
    cfgWrite(3'd2, {ADDR_B[7:0], ADDR_B[15:8], ADDR_B[23:16], ADDR_B[31:24]});
    cfgWrite(3'd3, {ADDR_B[39:32], ADDR_B[47:40], ADDR_A[39:32], ADDR_A[47:40]});
    cfgWrite(3'd0, ctrlWord(1'b1, 1'b0, 1'b0, 16'd0));
    runFrame(ADDR_A, 20, 1'b1, "R5", "match address A");
    runFrame(ADDR_B, 20, 1'b1, "R5", "match address B");
    runFrame({ADDR_A[47:32], ADDR_B[31:0]}, 20, 1'b0, "R5", "mixed halves");
    runFrame(48'h00_11_22_33_44_56, 20, 1'b0, "R5", "last byte differs");
    runFrame(48'h0A_0B_0C_0D_0E_0F, 20, 1'b0, "R4", "unrelated unicast");
  endtask

  task automatic testUniOff;
    cfgWrite(3'd0, ctrlWord(1'b0, 1'b1, 1'b0, 16'd0));
    runFrame(48'h0A_0B_0C_0D_0E_0F, 20, 1'b1, "R6", "unicast with filter off");
  endtask

  task automatic testHash;
    logic [47:0] grp [4];
    logic [31:0] c;
    logic [6:0]  idx;
    grp[0] = 48'h01_00_5E_00_00_01;
    grp[1] = 48'h33_33_00_00_00_01;
    grp[2] = 48'h01_80_C2_00_00_00;
    grp[3] = 48'h03_12_34_56_78_9A;
    for (int w = 0; w < 4; w++) cfgWrite(3'(4 + w), 32'd0);
    cfgWrite(3'd0, ctrlWord(1'b1, 1'b1, 1'b0, 16'd0));
    for (int g = 0; g < 4; g++) begin
      c   = destCrc(grp[g]);
      idx = c[29:23];
      cfgWrite(3'(4 + idx[6:5]), 32'd1 << idx[4:0]);
      runFrame(grp[g], 16, 1'b1, "R7", $sformatf("hash bit %0d set", idx));
      cfgWrite(3'(4 + idx[6:5]), ~(32'd1 << idx[4:0]));
      runFrame(grp[g], 16, 1'b0, "R7", $sformatf("hash bit %0d clear", idx));
      cfgWrite(3'(4 + idx[6:5]), 32'd0);
      cfgWrite(3'(4 + (idx[6:5] ^ 2'd1)), 32'd1 << idx[4:0]);
      runFrame(grp[g], 16, 1'b0, "R7", $sformatf("hash bit %0d wrong word", idx));
      cfgWrite(3'(4 + (idx[6:5] ^ 2'd1)), 32'd0);
    end
  endtask

  task automatic testMcastOff;
    cfgWrite(3'd0, ctrlWord(1'b1, 1'b0, 1'b0, 16'd0));
    runFrame(48'h01_00_5E_7F_00_09, 16, 1'b1, "R8", "multicast with hash off");
  endtask

  task automatic testBcast;
    cfgWrite(3'd0, ctrlWord(1'b1, 1'b1, 1'b1, 16'd20));
    runFrame(BCAST, 64, 1'b1, "R9", "broadcast all filters on");
    runFrame(BCAST, 10, 1'b0, "R10", "short broadcast is runt");
  endtask

  task automatic testRunt;
    cfgWrite(3'd0, ctrlWord(1'b0, 1'b0, 1'b1, 16'd20));
    runFrame(48'h0A_0B_0C_0D_0E_0F, 19, 1'b0, "R10", "one below minimum");
    runFrame(48'h0A_0B_0C_0D_0E_0F, 20, 1'b1, "R10", "at minimum");
    runFrame(48'h0A_0B_0C_0D_0E_0F, 90, 1'b1, "R10", "long frame");
  endtask

  task automatic testShort;
    cfgWrite(3'd0, ctrlWord(1'b1, 1'b0, 1'b0, 16'd0));
    runFrame(ADDR_A, 5, 1'b0, "R11", "five bytes");
    runFrame(ADDR_A, 6, 1'b1, "R11", "six bytes");
  endtask

  task automatic testRestart;
    cfgWrite(3'd0, ctrlWord(1'b1, 1'b0, 1'b0, 16'd0));
    fillFrame(48'h0A_0B_0C_0D_0E_0F, 3);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      inValid = 1'b1; inData = fb[i]; inStart = (i == 0); inEnd = 1'b0;
    end
    runFrame(ADDR_A, 12, 1'b1, "R12", "restart onto address A");
    fillFrame(ADDR_A, 8);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      inValid = 1'b1; inData = fb[i]; inStart = (i == 0); inEnd = 1'b0;
    end
    runFrame(48'h0A_0B_0C_0D_0E_0F, 12, 1'b0, "R12", "restart away from address A");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    testReset();
    testOpen();
    testUnicast();
    testUniOff();
    testHash();
    testMcastOff();
    testBcast();
    testRunt();
    testShort();
    testRestart();
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule